// File: doc/BRIEF.md
# NAND Bus Width Adapter

The adapter turns accesses from a 32-bit register port into cycles on a NAND I/O bus that is either 8 or 16 bits wide. A request names one of three windows: command, address or data. It also gives a size of 1, 2 or 4 bytes and, for a write, the data. The adapter breaks the request into as many NAND cycles as the size and the device width call for. The command window raises the command-latch line, the address window raises the address-latch line, and the data window raises neither. On a read, the bytes that come back are packed into a bus word, and the response returns that word.

Requests and responses each use a valid/ready pair. A request is taken only while `req_ready` is high, which is the case only when no access is in flight. The response stays valid, with stable data, until `rsp_ready` is seen high at a clock edge. Once the response is taken, the next request can be accepted. The channel configuration, the device-type field and the width bit, together with the wait count, are sampled when the request is accepted.

Top module: `nand_width_adapter`

## Requirements
- R1: With `chan_cfg[12]`=0 (8-bit device), a size code of 0, 1 or 2 (1, 2, 4 bytes; code 3 acts as 4 bytes) produces 1, 2 or 4 NAND cycles. The lowest byte goes first, on `nand_dout[7:0]`, and `nand_dout[15:8]` is zero.
- R2: With `chan_cfg[12]`=1 (16-bit device), a 2-byte access produces one cycle and a 4-byte access produces two. The low halfword goes first.
- R3: A 1-byte write to a 16-bit device produces one cycle that carries bits 15:0 of the write data.
- R4: A 1-byte read from a 16-bit device produces one cycle and returns only the low 8 bits of `nand_din`. Bits 31:8 of the result are zero.
- R5: Read data fills the response word from byte 0 upward: byte k on an 8-bit device, or halfword k on a 16-bit device. Bytes that no cycle filled read zero.
- R6: During a cycle, `nand_cle` is high only for command-window writes and `nand_ale` only for address-window writes. Data-window cycles raise neither line, and the two lines are never high together.
- R7: An access produces NAND cycles only when `chan_cfg[11:10]`=2'b10 (NAND type) and it is a write to window 0, 1 or 2 or a read of window 2. Every other access completes with no cycles and with zero data.
- R8: Each strobe stays high for exactly `cfg_wait`+1 clocks, with one low clock between cycles. `rsp_valid` rises `beats`*(`cfg_wait`+2) clocks after acceptance, or 1 clock after acceptance when there are no cycles.
- R9: `req_ready` is high only when the block is idle. `rsp_valid` and `rsp_rdata` hold steady while `rsp_ready` is low. Write responses carry zero data.
- R10: After reset the block is idle: `req_ready`=1, with `rsp_valid`, both strobes, `nand_cle` and `nand_ale` all at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken (idle) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_win | input | 2 | Window: 0 command, 1 address, 2 data, 3 reserved |
| req_size | input | 2 | 0 = 1 byte, 1 = 2 bytes, 2/3 = 4 bytes |
| req_wdata | input | 32 | Write data |
| chan_cfg | input | 3 | Bits 11:10 device type (2'b10 NAND), bit 12 width (1 = 16-bit) |
| cfg_wait | input | 4 | Extra strobe clocks per NAND cycle |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response taken |
| rsp_rdata | output | 32 | Assembled read data |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_wr_stb | output | 1 | Write strobe, active high |
| nand_rd_stb | output | 1 | Read strobe, active high |
| nand_dout | output | 16 | Write data to the NAND bus |
| nand_din | input | 16 | Read data from the NAND bus |

## Verification
A wrong beat index or a wrong lane choice shows up on the NAND bus within a single cycle, because bytes come out of order or land in the wrong position. It also shows up when the response returns, as a misplaced byte in `rsp_rdata`. A wrong wait counter or a wrong last-beat decision changes the strobe width or the number of strobes, so the fault is visible at the first strobe edge. Latency is checked against the computed clock count for every access. A stuck state after an ignored access shows up as `req_ready` staying low one clock after the response is taken.

// File: rtl/nwa_pkg.sv
package nwa_pkg;
  typedef enum logic [1:0] {
    WIN_CMD  = 2'd0,
    WIN_ADDR = 2'd1,
    WIN_DATA = 2'd2,
    WIN_RSVD = 2'd3
  } win_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_STROBE,
    ST_GAP,
    ST_RESP
  } state_e;

  localparam logic [1:0] TYPE_NAND = 2'b10;
endpackage

// File: rtl/nwa_beat_plan.sv
module nwa_beat_plan #(
  parameter int BEAT_W = 3
) (
  input  logic [1:0]        size,
  input  logic              wide,
  output logic [BEAT_W-1:0] beats
);
  logic [BEAT_W-1:0] nbytes;

  always_comb begin
    case (size)
      2'd0:    nbytes = BEAT_W'(1);
      2'd1:    nbytes = BEAT_W'(2);
      default: nbytes = BEAT_W'(4);
    endcase
    beats = wide ? BEAT_W'((32'(nbytes) + 32'd1) >> 1) : nbytes;
  end
endmodule

// File: rtl/nwa_strobe_timer.sv
module nwa_strobe_timer #(
  parameter int WAIT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [WAIT_W-1:0] wait_len,
  output logic              done
);
  logic [WAIT_W-1:0] cnt;

  assign done = run && (cnt == wait_len);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (!run)    cnt <= '0;
    else if (!done)   cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/nwa_read_pack.sv
module nwa_read_pack #(
  parameter int BUS_W  = 32,
  parameter int NAND_W = 16,
  parameter int BEAT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              capture,
  input  logic [BEAT_W-1:0] idx,
  input  logic              wide,
  input  logic              half_only,
  input  logic [NAND_W-1:0] din,
  output logic [BUS_W-1:0]  word
);
  localparam int LANES = BUS_W / 8;

  for (genvar g = 0; g < LANES; g++) begin : lane_g
    logic [7:0] lane;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lane <= '0;
      else if (clear) lane <= '0;
      else if (capture) begin
        if (!wide && idx == BEAT_W'(g))
          lane <= din[7:0];
        else if (wide && idx == BEAT_W'(g / 2))
          lane <= (g % 2 == 0) ? din[7:0] : (half_only ? 8'h00 : din[15:8]);
      end
    end
    assign word[8*g +: 8] = lane;
  end
endmodule

// File: rtl/nand_width_adapter.sv
module nand_width_adapter
  import nwa_pkg::*;
#(
  parameter int BUS_W  = 32,
  parameter int NAND_W = 16,
  parameter int WAIT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [1:0]        req_win,
  input  logic [1:0]        req_size,
  input  logic [BUS_W-1:0]  req_wdata,
  input  logic [12:10]      chan_cfg,
  input  logic [WAIT_W-1:0] cfg_wait,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [BUS_W-1:0]  rsp_rdata,
  output logic              nand_cle,
  output logic              nand_ale,
  output logic              nand_wr_stb,
  output logic              nand_rd_stb,
  output logic [NAND_W-1:0] nand_dout,
  input  logic [NAND_W-1:0] nand_din
);
  localparam int BUS_BYTES = BUS_W / 8;
  localparam int BEAT_W    = $clog2(BUS_BYTES) + 1;

  state_e            state;
  logic [BEAT_W-1:0] idx;
  logic [BEAT_W-1:0] beats;
  logic              l_write;
  win_e              l_win;
  logic [1:0]        l_size;
  logic [BUS_W-1:0]  l_data;
  logic              l_wide;
  logic [WAIT_W-1:0] l_wait;
  logic              accept;
  logic              effective;
  logic              tmr_done;
  logic              in_access;
  logic [BUS_W-1:0]  shifted;

  assign accept = (state == ST_IDLE) && req_valid;

  always_comb begin
    effective = 1'b0;
    if (chan_cfg[11:10] == TYPE_NAND) begin
      if (req_write) effective = (win_e'(req_win) != WIN_RSVD);
      else           effective = (win_e'(req_win) == WIN_DATA);
    end
  end

  nwa_beat_plan #(.BEAT_W(BEAT_W)) plan_i (
    .size  (l_size),
    .wide  (l_wide),
    .beats (beats)
  );

  nwa_strobe_timer #(.WAIT_W(WAIT_W)) timer_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (state == ST_STROBE),
    .wait_len (l_wait),
    .done     (tmr_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      idx     <= '0;
      l_write <= 1'b0;
      l_win   <= WIN_CMD;
      l_size  <= '0;
      l_data  <= '0;
      l_wide  <= 1'b0;
      l_wait  <= '0;
    end else begin
      case (state)
        ST_IDLE: if (req_valid) begin
          l_write <= req_write;
          l_win   <= win_e'(req_win);
          l_size  <= req_size;
          l_data  <= req_wdata;
          l_wide  <= chan_cfg[12];
          l_wait  <= cfg_wait;
          idx     <= '0;
          state   <= effective ? ST_STROBE : ST_RESP;
        end
        ST_STROBE: if (tmr_done)
          state <= (idx == beats - 1'b1) ? ST_RESP : ST_GAP;
        ST_GAP: begin
          idx   <= idx + 1'b1;
          state <= ST_STROBE;
        end
        ST_RESP: if (rsp_ready) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  nwa_read_pack #(.BUS_W(BUS_W), .NAND_W(NAND_W), .BEAT_W(BEAT_W)) pack_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (accept),
    .capture   ((state == ST_STROBE) && tmr_done && !l_write),
    .idx       (idx),
    .wide      (l_wide),
    .half_only (l_wide && (l_size == 2'd0)),
    .din       (nand_din),
    .word      (rsp_rdata)
  );

  always_comb begin
    if (l_wide) shifted = l_data >> (32'(idx) * 16);
    else        shifted = l_data >> (32'(idx) * 8);
    nand_dout = l_wide ? shifted[15:0] : {8'h00, shifted[7:0]};
  end

  assign in_access   = (state == ST_STROBE) || (state == ST_GAP);
  assign nand_cle    = in_access && l_write && (l_win == WIN_CMD);
  assign nand_ale    = in_access && l_write && (l_win == WIN_ADDR);
  assign nand_wr_stb = (state == ST_STROBE) && l_write;
  assign nand_rd_stb = (state == ST_STROBE) && !l_write;
  assign req_ready   = (state == ST_IDLE);
  assign rsp_valid   = (state == ST_RESP);
endmodule

// File: rtl/nwa_checker.sv
module nwa_checker #(
  parameter int BUS_W  = 32,
  parameter int NAND_W = 16,
  parameter int WAIT_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [12:10]      chan_cfg,
  input logic [WAIT_W-1:0] cfg_wait,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [BUS_W-1:0]  rsp_rdata,
  input logic              nand_cle,
  input logic              nand_ale,
  input logic              nand_wr_stb,
  input logic              nand_rd_stb,
  input logic [NAND_W-1:0] nand_dout
);
  logic              lat_wide;
  logic              lat_nand;
  logic [WAIT_W-1:0] lat_wait;
  logic              prev_stb;
  logic [WAIT_W:0]   run_len;
  logic              stb;

  assign stb = nand_wr_stb || nand_rd_stb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_wide <= 1'b0;
      lat_nand <= 1'b0;
      lat_wait <= '0;
      prev_stb <= 1'b0;
      run_len  <= '0;
    end else begin
      if (req_valid && req_ready) begin
        lat_wide <= chan_cfg[12];
        lat_nand <= (chan_cfg[11:10] == 2'b10);
        lat_wait <= cfg_wait;
      end
      prev_stb <= stb;
      run_len  <= stb ? run_len + 1'b1 : '0;
    end
  end

  assert_narrow_upper_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (nand_wr_stb && !lat_wide) |-> (nand_dout[15:8] == 8'h00));

  assert_latch_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(nand_cle && nand_ale));

  assert_read_no_latch_R6: assert property (@(posedge clk) disable iff (!rst_n)
    nand_rd_stb |-> (!nand_cle && !nand_ale));

  assert_non_nand_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!lat_nand && !req_ready) |-> !stb);

  assert_one_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(nand_wr_stb && nand_rd_stb));

  assert_strobe_width_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (prev_stb && !stb) |-> (run_len == ({1'b0, lat_wait} + {{WAIT_W{1'b0}}, 1'b1})));

  assert_rsp_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));

  assert_busy_after_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
endmodule

bind nand_width_adapter nwa_checker #(
  .BUS_W  (BUS_W),
  .NAND_W (NAND_W),
  .WAIT_W (WAIT_W)
) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .chan_cfg    (chan_cfg),
  .cfg_wait    (cfg_wait),
  .rsp_valid   (rsp_valid),
  .rsp_ready   (rsp_ready),
  .rsp_rdata   (rsp_rdata),
  .nand_cle    (nand_cle),
  .nand_ale    (nand_ale),
  .nand_wr_stb (nand_wr_stb),
  .nand_rd_stb (nand_rd_stb),
  .nand_dout   (nand_dout)
);

// File: tb/nand_width_adapter_tb_top.sv
module nand_width_adapter_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [1:0]  req_win = 2'd0;
  logic [1:0]  req_size = 2'd0;
  logic [31:0] req_wdata = '0;
  logic [12:10] chan_cfg = '0;
  logic [3:0]  cfg_wait = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [31:0] rsp_rdata;
  logic        nand_cle, nand_ale, nand_wr_stb, nand_rd_stb;
  logic [15:0] nand_dout;
  logic [15:0] nand_din;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;
  int rd_ctr = 0;
  int cur_wait = 0;
  logic [18:0] exp_q[$];
  logic [18:0] obs_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  nand_width_adapter dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_win(req_win), .req_size(req_size), .req_wdata(req_wdata),
    .chan_cfg(chan_cfg), .cfg_wait(cfg_wait),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .nand_cle(nand_cle), .nand_ale(nand_ale),
    .nand_wr_stb(nand_wr_stb), .nand_rd_stb(nand_rd_stb),
    .nand_dout(nand_dout), .nand_din(nand_din)
  );

  function automatic logic [15:0] pat(int k);
    return 16'(32'h3C00 + k * 32'h0A17);
  endfunction

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  // NAND-side model: records each cycle when its strobe falls
  logic        prev_stb = 1'b0;
  int          run_len = 0;
  logic [18:0] cur_ev = '0;
  always @(negedge clk) begin
    if (!rst_n) begin
      nand_din = pat(rd_ctr);
    end else if (nand_wr_stb || nand_rd_stb) begin
      run_len++;
      cur_ev = {nand_rd_stb, nand_cle, nand_ale, nand_rd_stb ? nand_din : nand_dout};
      if (nand_cle && nand_ale) chk(0, "R6 cle and ale together", 1, 0);
    end else if (prev_stb) begin
      obs_q.push_back(cur_ev);
      chk(run_len == cur_wait + 1, "R8 strobe width", run_len, cur_wait + 1);
      run_len = 0;
      if (cur_ev[18]) begin
        rd_ctr++;
        nand_din = pat(rd_ctr);
      end
    end
    prev_stb = nand_wr_stb || nand_rd_stb;
  end

  task automatic run_access(input logic w, input logic [1:0] win, input logic [1:0] size,
                            input logic [31:0] wd, input logic [31:0] cfg, input int wt,
                            input int hold, input string tag);
    bit          eff;
    bit          wide;
    int          nbytes, beats, lat, exp_lat;
    logic [31:0] exp_rd, got, held;
    logic [15:0] p, d;
    wide   = cfg[12];
    nbytes = (size == 2'd0) ? 1 : (size == 2'd1) ? 2 : 4;
    eff    = (cfg[11:10] == 2'b10) && (w ? (win != 2'd3) : (win == 2'd2));
    beats  = !eff ? 0 : (wide ? (nbytes + 1) / 2 : nbytes);
    exp_rd = '0;
    for (int b = 0; b < beats; b++) begin
      if (w) begin
        d = wide ? 16'(wd >> (16 * b)) : {8'h00, 8'(wd >> (8 * b))};
        exp_q.push_back({1'b0, win == 2'd0, win == 2'd1, d});
      end else begin
        p = pat(rd_ctr + b);
        exp_q.push_back({1'b1, 1'b0, 1'b0, p});
        if (!wide)             exp_rd[8*b +: 8]   = p[7:0];
        else if (nbytes == 1)  exp_rd[7:0]        = p[7:0];
        else                   exp_rd[16*b +: 16] = p;
      end
    end
    exp_lat  = eff ? beats * (wt + 2) : 1;
    cur_wait = wt;
    chk(req_ready == 1'b1, {"R9 ready before ", tag}, req_ready, 1);
    req_valid = 1'b1; req_write = w; req_win = win; req_size = size;
    req_wdata = wd; chan_cfg = cfg[12:10]; cfg_wait = 4'(wt);
    rsp_ready = (hold == 0);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    while (!rsp_valid && lat < 1000) begin
      @(negedge clk);
      lat++;
    end
    chk(lat == exp_lat, {"R8 latency ", tag}, lat, exp_lat);
    if (hold > 0) begin
      chk(!req_ready, {"R9 busy while response pending ", tag}, req_ready, 0);
      for (int h = 0; h < hold; h++) begin
        held = rsp_rdata;
        @(negedge clk);
        chk(rsp_valid && rsp_rdata == held, {"R9 response held ", tag}, rsp_rdata, held);
      end
      rsp_ready = 1'b1;
    end
    got = rsp_rdata;
    chk(got == exp_rd, {"rdata ", tag}, got, exp_rd);
    @(negedge clk);
    chk(!rsp_valid && req_ready, {"R9 idle after response ", tag}, {rsp_valid, req_ready}, 2'b01);
    chk(obs_q.size() == exp_q.size(), {"cycle count ", tag}, obs_q.size(), exp_q.size());
    for (int i = 0; i < obs_q.size() && i < exp_q.size(); i++)
      chk(obs_q[i] == exp_q[i], {"cycle content ", tag}, 32'(obs_q[i]), 32'(exp_q[i]));
    obs_q.delete();
    exp_q.delete();
  endtask

  localparam logic [31:0] NAND8  = 32'h0000_0800;
  localparam logic [31:0] NAND16 = 32'h0000_1800;
  localparam logic [31:0] NOR16  = 32'h0000_1000;
  localparam logic [31:0] TYPE1  = 32'h0000_0400;

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(req_ready && !rsp_valid && !nand_wr_stb && !nand_rd_stb && !nand_cle && !nand_ale,
        "R10 reset outputs", {req_ready, rsp_valid, nand_wr_stb, nand_rd_stb, nand_cle, nand_ale},
        6'b100000);
    rst_n = 1'b1;
    @(negedge clk);
    run_access(1, 2'd0, 2'd2, 32'hA1B2C3D4, NAND8, 0, 0, "R1 R6 cmd 4B 8bit");
    run_access(1, 2'd1, 2'd1, 32'h00005566, NAND8, 1, 0, "R1 R6 addr 2B 8bit");
    run_access(1, 2'd2, 2'd0, 32'hFFFFFF7E, NAND8, 2, 0, "R1 R6 data 1B 8bit");
    run_access(1, 2'd2, 2'd3, 32'h13572468, NAND8, 0, 0, "R1 size3 as 4B");
    run_access(1, 2'd2, 2'd2, 32'hDEADBEEF, NAND16, 1, 0, "R2 data 4B 16bit");
    run_access(1, 2'd0, 2'd1, 32'h0000CAFE, NAND16, 0, 0, "R2 R6 cmd 2B 16bit");
    run_access(1, 2'd2, 2'd0, 32'h1234ABCD, NAND16, 0, 0, "R3 1B write 16bit");
    run_access(0, 2'd2, 2'd2, 32'h0, NAND8, 3, 0, "R5 R1 read 4B 8bit");
    run_access(0, 2'd2, 2'd1, 32'h0, NAND8, 0, 0, "R5 read 2B 8bit");
    run_access(0, 2'd2, 2'd2, 32'h0, NAND16, 1, 0, "R2 R5 read 4B 16bit");
    run_access(0, 2'd2, 2'd1, 32'h0, NAND16, 0, 0, "R2 R5 read 2B 16bit");
    run_access(0, 2'd2, 2'd0, 32'h0, NAND16, 2, 0, "R4 read 1B 16bit");
    run_access(1, 2'd0, 2'd2, 32'h11223344, NOR16, 0, 0, "R7 write non-NAND");
    run_access(0, 2'd2, 2'd2, 32'h0, NOR16, 0, 0, "R7 read non-NAND");
    run_access(1, 2'd2, 2'd2, 32'h55667788, TYPE1, 0, 0, "R7 write type 01");
    run_access(0, 2'd0, 2'd2, 32'h0, NAND8, 0, 0, "R7 read cmd window");
    run_access(1, 2'd3, 2'd2, 32'h99AABBCC, NAND8, 0, 0, "R7 reserved window");
    run_access(0, 2'd2, 2'd2, 32'h0, NAND8, 1, 3, "R9 held read response");
    run_access(1, 2'd1, 2'd2, 32'h0F1E2D3C, NAND16, 5, 2, "R9 held write response");
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=%h expected=%h", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule